// File: doc/BRIEF.md
# Secure Attribution Register Bank

This block is the configuration and fault-status register bank for a security attribution unit. It sits on a simple register bus with a word address, a write enable, write data, registered read data and a secure attribute on every access. It holds a two-bit control register, a read-only type register that reports the region count, a region number register, and one base and one limit register per region. The base and limit registers are reached only through the region number, which serves as an index. It also holds a fault status register that software clears by writing ones, and a fault address register.

Fault logic elsewhere in the chip drives a set mask into the status register and a capture strobe with an address into the fault address register. Every accepted write to a base or limit register raises a one-cycle invalidate pulse, so that cached attribution results downstream can be dropped. The region count, the address width and whether the feature is present at all are parameters. With the feature absent, an access to the bank's window is not decoded and gets an error response.

Byte offsets of the window, with the word index `bus_addr` equal to the byte offset divided by 4: control 0xDD0 (word 0x374), type 0xDD4 (0x375), region number 0xDD8 (0x376), region base 0xDDC (0x377), region limit 0xDE0 (0x378), fault status 0xDE4 (0x379), fault address 0xDE8 (0x37A).

Top module: `secattr_regbank`

## Requirements
- R1: After reset every register reads as zero except the type register, and `bus_rdata`, `inv_pulse` and `bus_err` are 0.
- R2: An access inside the window with `bus_secure` low reads as zero, changes no register and raises no invalidate pulse.
- R3: A secure write to control (word 0x374) stores only write-data bits 1:0, and bits 31:2 read as zero.
- R4: The type register (word 0x375) reads as `NUM_REGIONS`, and writes to it have no effect.
- R5: A secure write to region number (word 0x376) with a value of `NUM_REGIONS` or more is dropped and the previous value is kept. A smaller value is stored.
- R6: Base (word 0x377) and limit (word 0x378) reach the entry selected by the current region number. A base write stores the data with bits 4:0 cleared. A limit write stores the data with bits 4:2 cleared and bits 1:0 and 31:5 kept.
- R7: A secure write to fault status (word 0x379) clears every status bit whose write-data bit is 1 and leaves the others unchanged.
- R8: `flt_set` ORs into fault status on every clock. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: A secure write to fault address (word 0x37A) stores all 32 bits and leaves fault status alone. `flt_cap` loads `flt_addr` into fault address and takes priority over a write in the same cycle.
- R10: `inv_pulse` is high for exactly the one cycle after each accepted secure write to base or limit, and low otherwise.
- R11: With `FEATURE_EN` = 0, any access to the window raises `bus_err` for the one cycle after it, reads return zero and no register exists.
- R12: Read data is registered. It appears in the cycle after a read access and holds until the next read. A read outside the window returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Bad-address error response, one cycle after the access |
| flt_set | input | 32 | Fault status bits to set |
| flt_cap | input | 1 | Capture strobe for the fault address |
| flt_addr | input | 32 | Fault address to capture |
| inv_pulse | output | 1 | One-cycle invalidate request |

## Verification
Every result of an access is due exactly one clock after the edge that samples it. This covers the read data, the error response, the invalidate pulse and the register updates that a later read observes. Hardware sets and captures also act at that same edge. The bench drives each access on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge against a behavioural model that has just taken the same step. A register's new value is therefore only visible to a read issued in a later cycle, and the model reproduces that. A second instance with the feature disabled sees the same stimulus, which covers the error path.

// File: rtl/secattr_pkg.sv
package secattr_pkg;

   localparam int SA_DW = 32;

   // word indices (byte offset / 4) of the bank's window
   localparam logic [9:0] SA_W_CTRL = 10'h374;
   localparam logic [9:0] SA_W_TYPE = 10'h375;
   localparam logic [9:0] SA_W_RNR  = 10'h376;
   localparam logic [9:0] SA_W_BASE = 10'h377;
   localparam logic [9:0] SA_W_LIM  = 10'h378;
   localparam logic [9:0] SA_W_FST  = 10'h379;
   localparam logic [9:0] SA_W_FAD  = 10'h37A;

   // bits kept on a base / limit write
   localparam logic [SA_DW-1:0] SA_BASE_KEEP = 32'hFFFF_FFE0;
   localparam logic [SA_DW-1:0] SA_LIM_KEEP  = 32'hFFFF_FFE3;

   typedef enum logic [2:0] {
      SR_CTRL,
      SR_TYPE,
      SR_RNR,
      SR_BASE,
      SR_LIM,
      SR_FST,
      SR_FAD,
      SR_NONE
   } sa_reg_e;

endpackage

// File: rtl/secattr_decode.sv
module secattr_decode
   import secattr_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output sa_reg_e           reg_sel,
   output logic              in_win
);

   localparam int HI_W = ADDR_W - 10;

   logic upper_zero;
   logic [9:0] low_word;

   generate
      if (HI_W > 0) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:10] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign low_word = addr[9:0];

   always_comb begin
      reg_sel = SR_NONE;
      if (upper_zero) begin
         case (low_word)
            SA_W_CTRL: reg_sel = SR_CTRL;
            SA_W_TYPE: reg_sel = SR_TYPE;
            SA_W_RNR:  reg_sel = SR_RNR;
            SA_W_BASE: reg_sel = SR_BASE;
            SA_W_LIM:  reg_sel = SR_LIM;
            SA_W_FST:  reg_sel = SR_FST;
            SA_W_FAD:  reg_sel = SR_FAD;
            default:   reg_sel = SR_NONE;
         endcase
      end
   end

   assign in_win = (reg_sel != SR_NONE);

endmodule

// File: rtl/secattr_region_file.sv
module secattr_region_file
   import secattr_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int IDX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             idx_ok,
   input  logic             wr_base,
   input  logic             wr_lim,
   input  logic [SA_DW-1:0] wdata,
   output logic [SA_DW-1:0] base_rd,
   output logic [SA_DW-1:0] lim_rd
);

   logic [SA_DW-1:0] base_q [NUM_REGIONS];
   logic [SA_DW-1:0] lim_q  [NUM_REGIONS];

   generate
      for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
         logic hit;
         assign hit = idx_ok && (idx == IDX_W'(r));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q[r] <= '0;
               lim_q[r]  <= '0;
            end else begin
               if (wr_base && hit) base_q[r] <= wdata & SA_BASE_KEEP;
               if (wr_lim && hit)  lim_q[r]  <= wdata & SA_LIM_KEEP;
            end
         end
      end
   endgenerate

   always_comb begin
      base_rd = '0;
      lim_rd  = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (idx_ok && (idx == IDX_W'(r))) begin
            base_rd = base_q[r];
            lim_rd  = lim_q[r];
         end
      end
   end

endmodule

// File: rtl/secattr_fault.sv
module secattr_fault
   import secattr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [SA_DW-1:0] clr_mask,
   input  logic [SA_DW-1:0] set_mask,
   input  logic             wr_en,
   input  logic [SA_DW-1:0] wr_addr,
   input  logic             cap,
   input  logic [SA_DW-1:0] cap_addr,
   output logic [SA_DW-1:0] status,
   output logic [SA_DW-1:0] faddr
);

   logic [SA_DW-1:0] clr_eff;

   assign clr_eff = clr_en ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         faddr  <= '0;
      end else begin
         // hardware set wins over a software clear of the same bit
         status <= (status & ~clr_eff) | set_mask;
         if (cap)        faddr <= cap_addr;
         else if (wr_en) faddr <= wr_addr;
      end
   end

endmodule

// File: rtl/secattr_regbank.sv
module secattr_regbank
   import secattr_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 10,
   parameter bit FEATURE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_secure,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic [31:0]       flt_set,
   input  logic              flt_cap,
   input  logic [31:0]       flt_addr,
   output logic              inv_pulse
);

   localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > 255) begin : g_bad_nr
         $error("secattr_regbank: NUM_REGIONS must be 1..255");
      end
      if (ADDR_W < 10) begin : g_bad_aw
         $error("secattr_regbank: ADDR_W must be at least 10");
      end
   endgenerate

   sa_reg_e reg_sel;
   logic    in_win;

   secattr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (bus_addr),
      .reg_sel (reg_sel),
      .in_win  (in_win)
   );

   logic [31:0] rdata_q;
   logic        err_q;
   logic        inv_q;
   logic [31:0] sfsr_w;
   logic [31:0] sfar_w;
   logic [31:0] rnr_w;

   generate
      if (FEATURE_EN) begin : g_on
         logic             sec_wr;
         logic             sec_rd;
         logic [1:0]       ctrl_q;
         logic [IDX_W-1:0] rnr_q;
         logic             rnr_ok;
         logic             wr_base;
         logic             wr_lim;
         logic [31:0]      base_rd;
         logic [31:0]      lim_rd;
         logic [31:0]      rd_mux;

         assign sec_wr = bus_sel && bus_wr && bus_secure;
         assign sec_rd = bus_sel && !bus_wr && bus_secure;
         assign rnr_ok = (32'(rnr_q) < 32'(NUM_REGIONS));
         assign wr_base = sec_wr && (reg_sel == SR_BASE);
         assign wr_lim  = sec_wr && (reg_sel == SR_LIM);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctrl_q <= '0;
               rnr_q  <= '0;
            end else if (sec_wr) begin
               if (reg_sel == SR_CTRL) ctrl_q <= bus_wdata[1:0];
               if (reg_sel == SR_RNR && bus_wdata < 32'(NUM_REGIONS))
                  rnr_q <= bus_wdata[IDX_W-1:0];
            end
         end

         secattr_region_file #(
            .NUM_REGIONS (NUM_REGIONS),
            .IDX_W       (IDX_W)
         ) u_regions (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (rnr_q),
            .idx_ok  (rnr_ok),
            .wr_base (wr_base),
            .wr_lim  (wr_lim),
            .wdata   (bus_wdata),
            .base_rd (base_rd),
            .lim_rd  (lim_rd)
         );

         secattr_fault u_fault (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_en   (sec_wr && (reg_sel == SR_FST)),
            .clr_mask (bus_wdata),
            .set_mask (flt_set),
            .wr_en    (sec_wr && (reg_sel == SR_FAD)),
            .wr_addr  (bus_wdata),
            .cap      (flt_cap),
            .cap_addr (flt_addr),
            .status   (sfsr_w),
            .faddr    (sfar_w)
         );

         always_comb begin
            case (reg_sel)
               SR_CTRL: rd_mux = {30'b0, ctrl_q};
               SR_TYPE: rd_mux = 32'(NUM_REGIONS);
               SR_RNR:  rd_mux = 32'(rnr_q);
               SR_BASE: rd_mux = base_rd;
               SR_LIM:  rd_mux = lim_rd;
               SR_FST:  rd_mux = sfsr_w;
               SR_FAD:  rd_mux = sfar_w;
               default: rd_mux = '0;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_q <= '0;
               inv_q   <= 1'b0;
            end else begin
               inv_q <= (wr_base || wr_lim) && rnr_ok;
               if (bus_sel && !bus_wr) rdata_q <= sec_rd ? rd_mux : '0;
            end
         end

         assign err_q = 1'b0;
         assign rnr_w = 32'(rnr_q);
      end else begin : g_off
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= bus_sel && in_win;
         end
         assign rdata_q = '0;
         assign inv_q   = 1'b0;
         assign sfsr_w  = '0;
         assign sfar_w  = '0;
         assign rnr_w   = '0;
      end
   endgenerate

   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;
   assign inv_pulse = inv_q;

endmodule

// File: rtl/secattr_chk.sv
module secattr_chk #(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 10,
   parameter bit FEATURE_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_secure,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              inv_pulse,
   input logic              bus_err,
   input logic [31:0]       sfsr,
   input logic [31:0]       sfar,
   input logic [31:0]       rnr,
   input logic [31:0]       flt_set,
   input logic              flt_cap,
   input logic [31:0]       flt_addr
);

   logic bl_acc;
   assign bl_acc = (bus_addr == ADDR_W'(10'h377)) || (bus_addr == ADDR_W'(10'h378));

   AST_NS_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_secure) |=> !inv_pulse); // R2

   AST_NS_FST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_secure && flt_set == 32'b0) |=> $stable(sfsr)); // R2

   AST_RNR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rnr < 32'(NUM_REGIONS)); // R5

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (FEATURE_EN && flt_set != 32'b0) |=> ((sfsr & $past(flt_set)) == $past(flt_set))); // R8

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (FEATURE_EN && flt_cap) |=> (sfar == $past(flt_addr))); // R9

   AST_INV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_pulse |-> $past(bus_sel && bus_wr && bus_secure && bl_acc)); // R10

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (!FEATURE_EN && $past(bus_sel))); // R11

endmodule

bind secattr_regbank secattr_chk #(
   .NUM_REGIONS (NUM_REGIONS),
   .ADDR_W      (ADDR_W),
   .FEATURE_EN  (FEATURE_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_secure (bus_secure),
   .bus_addr   (bus_addr),
   .inv_pulse  (inv_pulse),
   .bus_err    (bus_err),
   .sfsr       (sfsr_w),
   .sfar       (sfar_w),
   .rnr        (rnr_w),
   .flt_set    (flt_set),
   .flt_cap    (flt_cap),
   .flt_addr   (flt_addr)
);

// File: tb/sim_secattr_regbank.sv
`timescale 1ns/1ps
module sim_secattr_regbank;

   localparam int NR = 8;
   localparam logic [9:0] A_CTRL = 10'h374, A_TYPE = 10'h375, A_RNR = 10'h376,
                          A_BASE = 10'h377, A_LIM = 10'h378, A_FST = 10'h379,
                          A_FAD = 10'h37A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, sec = 1'b0, cap = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0, fset = '0, faddr = '0;
   logic [31:0] rd0, rd1;
   logic        err0, err1, inv0, inv1;

   always #5 clk = ~clk;

   secattr_regbank #(.NUM_REGIONS(NR), .ADDR_W(10), .FEATURE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_secure(sec), .bus_rdata(rd0), .bus_err(err0),
      .flt_set(fset), .flt_cap(cap), .flt_addr(faddr), .inv_pulse(inv0));

   secattr_regbank #(.NUM_REGIONS(NR), .ADDR_W(10), .FEATURE_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_secure(sec), .bus_rdata(rd1), .bus_err(err1),
      .flt_set(fset), .flt_cap(cap), .flt_addr(faddr), .inv_pulse(inv1));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [31:0] m_ctrl = 0, m_rnr = 0, m_fst = 0, m_fad = 0;
   logic [31:0] m_base [NR];
   logic [31:0] m_lim  [NR];
   logic [31:0] e_rd0 = 0;
   logic        e_inv0 = 0, e_err1 = 0;

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [31:0] model_read(logic [9:0] a);
      case (a)
         A_CTRL: return m_ctrl;
         A_TYPE: return 32'(NR);
         A_RNR:  return m_rnr;
         A_BASE: return m_base[m_rnr];
         A_LIM:  return m_lim[m_rnr];
         A_FST:  return m_fst;
         A_FAD:  return m_fad;
         default: return 32'b0;
      endcase
   endfunction

   // one bus cycle: drive at falling edge, compare at the next falling edge
   task automatic step(string tag, bit s, bit w, logic [9:0] a, logic [31:0] d, bit sc,
                       logic [31:0] hs = 0, bit hc = 0, logic [31:0] ha = 0);
      logic [31:0] clr;
      bit win, wfad;
      sel = s; wr = w; addr = a; wdata = d; sec = sc;
      fset = hs; cap = hc; faddr = ha;
      @(posedge clk);
      @(negedge clk);
      win = (a >= A_CTRL) && (a <= A_FAD);
      e_inv0 = 0;
      e_err1 = s && win;
      if (s && !w) e_rd0 = (sc && win) ? model_read(a) : 32'b0;
      clr = 0; wfad = 0;
      if (s && w && sc && win) begin
         case (a)
            A_CTRL: m_ctrl = d & 32'h3;
            A_RNR:  if (d < NR) m_rnr = d;
            A_BASE: begin m_base[m_rnr] = d & ~32'h1f; e_inv0 = 1; end
            A_LIM:  begin m_lim[m_rnr]  = d & ~32'h1c; e_inv0 = 1; end
            A_FST:  clr = d;
            A_FAD:  wfad = 1;
            default: ;
         endcase
      end
      m_fst = (m_fst & ~clr) | hs;
      if (hc) m_fad = ha;
      else if (wfad) m_fad = d;
      chk(tag, "u0 rdata", rd0, e_rd0);
      chk(tag, "u0 inv", 32'(inv0), 32'(e_inv0));
      chk(tag, "u0 err", 32'(err0), 0);
      chk(tag, "u1 rdata (R11)", rd1, 0);
      chk(tag, "u1 err (R11)", 32'(err1), 32'(e_err1));
      chk(tag, "u1 inv (R11)", 32'(inv1), 0);
      sel = 0; fset = 0; cap = 0;
   endtask

   task automatic rd(string tag, logic [9:0] a);
      step(tag, 1, 0, a, 32'b0, 1);
   endtask

   task automatic wrs(string tag, logic [9:0] a, logic [31:0] d);
      step(tag, 1, 1, a, d, 1);
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual hang expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_lim[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: outputs are zero during reset
      chk("R1", "rdata in reset", rd0, 0);
      chk("R1", "inv in reset", 32'(inv0), 0);
      rst_n = 1'b1;
      step("R1", 0, 0, 0, 0, 0);
      rd("R1", A_CTRL); rd("R1", A_RNR); rd("R1", A_BASE); rd("R1", A_LIM);
      rd("R1", A_FST);  rd("R1", A_FAD);
      // R4: type register
      rd("R4", A_TYPE);
      wrs("R4", A_TYPE, 32'h5);
      rd("R4", A_TYPE);
      // R3: control keeps bits 1:0
      wrs("R3", A_CTRL, 32'hFFFF_FFFF);
      rd("R3", A_CTRL);
      wrs("R3", A_CTRL, 32'h0000_0006);
      rd("R3", A_CTRL);
      // R2: non-secure accesses
      step("R2", 1, 1, A_CTRL, 32'h0, 0);
      rd("R2", A_CTRL);
      step("R2", 1, 0, A_CTRL, 32'h0, 0);
      step("R2", 1, 1, A_BASE, 32'hFFFF_FFFF, 0);
      step("R2", 1, 1, A_RNR, 32'h3, 0);
      rd("R2", A_RNR); rd("R2", A_BASE);
      // R5: region number range
      wrs("R5", A_RNR, 32'h3);  rd("R5", A_RNR);
      wrs("R5", A_RNR, 32'h8);  rd("R5", A_RNR);
      wrs("R5", A_RNR, 32'hFFFF_FFFF); rd("R5", A_RNR);
      wrs("R5", A_RNR, 32'h7);  rd("R5", A_RNR);
      // R6 / R10: indexed base and limit with masking and invalidate
      wrs("R6", A_RNR, 32'h2);
      wrs("R10", A_BASE, 32'hFFFF_FFFF);
      wrs("R10", A_LIM, 32'hFFFF_FFFF);
      rd("R6", A_BASE); rd("R6", A_LIM);
      wrs("R6", A_RNR, 32'h5);
      rd("R6", A_BASE); rd("R6", A_LIM);
      wrs("R10", A_BASE, 32'h1234_567F);
      wrs("R10", A_LIM, 32'hABCD_EF1F);
      wrs("R6", A_RNR, 32'h2);
      rd("R6", A_BASE);
      wrs("R6", A_RNR, 32'h5);
      rd("R6", A_BASE); rd("R6", A_LIM);
      // R7 / R8: fault status
      step("R8", 0, 0, 0, 0, 0, 32'h0000_F0F0);
      rd("R8", A_FST);
      wrs("R7", A_FST, 32'h0000_00F0);
      rd("R7", A_FST);
      step("R8", 1, 1, A_FST, 32'h0000_3000, 1, 32'h0000_1000);
      rd("R8", A_FST);
      wrs("R7", A_FST, 32'hFFFF_FFFF);
      rd("R7", A_FST);
      // R9: fault address
      wrs("R9", A_FAD, 32'hDEAD_BEEF);
      rd("R9", A_FAD); rd("R9", A_FST);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 32'h0000_1234);
      rd("R9", A_FAD);
      step("R9", 1, 1, A_FAD, 32'h5555_AAAA, 1, 0, 1, 32'h0BAD_F00D);
      rd("R9", A_FAD);
      // R11: non-secure window access also raises the error when disabled
      step("R11", 1, 0, A_SFAR_DUMMY(), 0, 0);
      // R12: out-of-window read and hold behaviour
      rd("R12", 10'h100);
      rd("R12", A_TYPE);
      step("R12", 0, 0, 0, 0, 0);
      step("R12", 1, 1, 10'h100, 32'hFFFF_FFFF, 1);
      rd("R12", 10'h3FF);
      step("R12", 0, 0, 0, 0, 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [9:0] A_SFAR_DUMMY();
      return A_FAD;
   endfunction

endmodule